// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs register reads and writes on a two-wire PHY management bus. It divides the system clock down to make the management clock (MDC) and drives or samples the data line. The bidirectional pin appears as three separate signals: an output value, an output enable and an input. A host presents one request at a time. Each request gives the direction, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data. The block raises `busy` for the whole transaction and ends it with a one-cycle `done` pulse. With that pulse it presents the read data and a flag that marks a missing acknowledge.

Every bus transaction is 65 MDC periods long, counted from period 0:

- Periods 0 to 31 are the preamble.
- Periods 32 to 45 carry the 14-bit header.
- Periods 46 and 47 are the turnaround.
- Periods 48 to 63 carry the data.
- Period 64 is an idle period.

On a read, the master releases the line from period 46 onward. It samples the acknowledge at the rising edge of period 47 and the data at the rising edges of periods 48 to 63. A failed acknowledge does not shorten the frame, so every PHY on the bus stays aligned. When single-PHY mode is set, a read aimed at a non-zero PHY address is answered at once and the bus is not touched.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy`, `done` and `ack_fail` are 0 and `rd_data` is 0.
- R2: While idle, MDC stays low. While a transaction runs, each MDC period lasts 2*CLK_HALF system cycles, and every transaction that is not rejected produces exactly 65 MDC rising edges.
- R3: In periods 0 to 31 (the preamble), the line is driven high.
- R4: In periods 32 to 45, the header is driven MSB first in this order: start pattern 01, opcode (10 for a read, 01 for a write), the 5-bit PHY address, then the 5-bit register address.
- R5: On a write, periods 46 and 47 carry the turnaround 10 and periods 48 to 63 carry the write data MSB first. Period 64 is driven high. The output enable stays 1 through period 64 and returns to 0 with `done`. A write returns `rd_data` 0 and `ack_fail` 0.
- R6: On a read, `mdio_oe` is 0 in periods 46 through 64.
- R7: On a read, `mdio_in` is sampled at the rising MDC edge of period 47 as the acknowledge, where low means the PHY responded. When the acknowledge is good, data is sampled MSB first at the rising edges of periods 48 to 63 and appears on `rd_data` with `done`, with `ack_fail` 0.
- R8: On a read whose acknowledge is high, all 65 periods still run, `rd_data` is 0 and `ack_fail` is 1.
- R9: While MDC is high and the line is driven, `mdio_out` does not change.
- R10: `busy` rises in the cycle after a request is accepted and falls together with the one-cycle `done` pulse. A request presented while `busy` is high is ignored.
- R11: When `single_phy` is 1, a read to any PHY address other than 0 produces `done` in the cycle after acceptance, with `rd_data` 0, `ack_fail` 1, no MDC edge and `busy` staying 0. Writes, and reads to address 0, run normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| single_phy | input | 1 | Rejects reads to non-zero PHY addresses |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, updated with `done` |
| ack_fail | output | 1 | Acknowledge missing or read rejected, updated with `done` |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input |

## Verification
The hardest situation to reach is a read with a failed acknowledge. The PHY-side response has to line up with the master's own MDC edges, and the master must still run all 16 data periods while the line shows a pattern it is meant to discard. The bench contains a small PHY model that counts falling MDC edges. It places the acknowledge level and the data bits on `mdio_in` for the exact periods, and can hold the acknowledge high while presenting all-ones data. A second hard case is a request that arrives mid-frame. The bench injects one with every field inverted and then checks that the captured frame, the edge count and the result all belong to the first request.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int HDR_BITS  = 14;
  localparam int DATA_BITS = 16;
  localparam int TAIL_BITS = 18;  // turnaround + data

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] TA_WRITE  = 2'b10;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
// Divides the system clock into MDC and flags the cycle before each edge.
module mdio_mdc_gen #(
  parameter int unsigned CLK_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int unsigned CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          term;

  assign term    = (cnt == CW'(CLK_HALF - 1));
  assign rise_ev = run && term && !mdc;
  assign fall_ev = run && term && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_shift.sv
`timescale 1ns/1ps
// Holds the whole outgoing frame; MSB is the bit on the wire.
module mdio_frame_shift #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_out
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b1};
  end

  assign bit_out = sr[W-1];
endmodule

// File: rtl/mdio_rd_capture.sv
`timescale 1ns/1ps
// Collects read bits MSB first.
module mdio_rd_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= {q[W-2:0], bit_in};
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_HALF = 2,
  parameter int unsigned PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic        single_phy,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        ack_fail,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int FRAME_W    = PRE_LEN + HDR_BITS + TAIL_BITS;
  localparam int LAST_P     = FRAME_W;            // idle period
  localparam int REL_P      = PRE_LEN + HDR_BITS; // read release period
  localparam int ACK_P      = REL_P + 1;
  localparam int DATA_FIRST = REL_P + 2;
  localparam int DATA_LAST  = DATA_FIRST + DATA_BITS - 1;
  localparam int PW         = $clog2(LAST_P + 1);

  seq_state_t state;
  logic [PW-1:0] per;
  logic is_rd, ack_bad;
  logic rise_ev, fall_ev, run;
  logic accept, reject, start;
  logic cap_en;
  logic [DATA_BITS-1:0] cap_q;
  logic [FRAME_W-1:0] frame_val;

  assign accept = req_valid && (state == SEQ_IDLE);
  assign reject = accept && !req_write && single_phy && (req_phy != 5'd0);
  assign start  = accept && !reject;
  assign run    = (state == SEQ_RUN);

  assign frame_val = {{PRE_LEN{1'b1}}, START_PAT,
                      (req_write ? OP_WRITE : OP_READ),
                      req_phy, req_reg, TA_WRITE, req_wdata};

  assign cap_en = rise_ev && is_rd &&
                  (per >= PW'(DATA_FIRST)) && (per <= PW'(DATA_LAST));

  mdio_mdc_gen #(.CLK_HALF(CLK_HALF)) u_mdc (
    .clk(clk), .rst(rst), .run(run),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(start), .load_val(frame_val),
    .shift(fall_ev), .bit_out(mdio_out)
  );

  mdio_rd_capture #(.W(DATA_BITS)) u_cap (
    .clk(clk), .rst(rst), .clr(start), .en(cap_en),
    .bit_in(mdio_in && !ack_bad), .q(cap_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      per      <= '0;
      is_rd    <= 1'b0;
      ack_bad  <= 1'b0;
      mdio_oe  <= 1'b0;
      rd_data  <= '0;
      ack_fail <= 1'b0;
    end else begin
      done <= 1'b0;
      if (reject) begin
        done     <= 1'b1;
        rd_data  <= '0;
        ack_fail <= 1'b1;
      end else if (start) begin
        state   <= SEQ_RUN;
        busy    <= 1'b1;
        per     <= '0;
        is_rd   <= !req_write;
        ack_bad <= 1'b0;
        mdio_oe <= 1'b1;
      end else if (run) begin
        if (rise_ev && is_rd && per == PW'(ACK_P))
          ack_bad <= mdio_in;
        if (fall_ev) begin
          if (per == PW'(LAST_P)) begin
            state    <= SEQ_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            mdio_oe  <= 1'b0;
            rd_data  <= (is_rd && !ack_bad) ? cap_q : '0;
            ack_fail <= is_rd && ack_bad;
          end else begin
            per <= per + 1'b1;
            if (is_rd && per == PW'(REL_P - 1))
              mdio_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [4:0]  req_phy,
  input logic        single_phy,
  input logic        busy,
  input logic        done,
  input logic [15:0] rd_data,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe
);
  assert_idle_mdc_low_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  assert_drive_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (mdc && mdio_oe) |-> $stable(mdio_out));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_no_drive_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  assert_reject_fast_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !req_write && single_phy && req_phy != 5'd0)
    |=> (done && !busy && !mdc && rd_data == 16'd0));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_phy(req_phy), .single_phy(single_phy), .busy(busy), .done(done),
  .rd_data(rd_data), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int NVEC = 7;
  // {write, single, ack_ok, phy[5], reg[5], wdata[16], phy_rdata[16]}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 5'd1,  5'd2,  16'h0000, 16'hA55A},
    {1'b1, 1'b0, 1'b1, 5'd31, 5'd31, 16'h8001, 16'h0000},
    {1'b0, 1'b0, 1'b0, 5'd3,  5'd0,  16'h0000, 16'hFFFF},
    {1'b0, 1'b1, 1'b1, 5'd0,  5'd5,  16'h0000, 16'h1234},
    {1'b0, 1'b1, 1'b1, 5'd7,  5'd9,  16'h0000, 16'hBEEF},
    {1'b1, 1'b1, 1'b1, 5'd9,  5'd17, 16'h5AC3, 16'h0000},
    {1'b0, 1'b0, 1'b1, 5'd16, 5'd1,  16'h0000, 16'h0001}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, single_phy = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, ack_fail, mdc, mdio_out, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_in = 1'b1;

  int checks = 0, errors = 0;
  int rises = 0, falls = 0, r9_viol = 0;
  bit finished = 0;
  logic cap_out [0:79];
  logic cap_oe  [0:79];
  time rise_t [0:2];
  logic ack_lvl = 1'b0;
  logic [15:0] phy_rdata = '0;
  logic prev_out = 1'b0;

  mdio_master #(.CLK_HALF(HALF), .PRE_LEN(32)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .single_phy(single_phy), .busy(busy), .done(done), .rd_data(rd_data),
    .ack_fail(ack_fail), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .mdio_in(mdio_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bus observer: capture driven bits at each rising MDC edge.
  always @(posedge mdc) begin
    if (rises < 80) begin
      cap_out[rises] = mdio_out;
      cap_oe[rises]  = mdio_oe;
    end
    if (rises < 3) rise_t[rises] = $time;
    rises = rises + 1;
  end

  // PHY model: new bit at each falling MDC edge (period index = falls).
  always @(negedge mdc) begin
    int f;
    f = falls + 1;
    falls = f;
    if (f == 47)                 mdio_in <= ack_lvl;
    else if (f >= 48 && f <= 63) mdio_in <= phy_rdata[63 - f];
    else                         mdio_in <= 1'b1;
  end

  // R9 monitor: driven output must not move while MDC is high.
  always @(negedge clk) begin
    if (!rst && mdc && mdio_oe && mdio_out !== prev_out) r9_viol++;
    prev_out = mdio_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic wr, input logic sgl, input logic ack_ok,
                     input logic [4:0] phy, input logic [4:0] rg,
                     input logic [15:0] wd, input logic [15:0] rdv,
                     input bit poke);
    logic [63:0] ef;
    bit rejected;
    int waited, pre_bad, hdr_bad, tail_bad, rel_bad;
    logic [15:0] exp_rd;
    logic exp_af;
    single_phy = sgl;
    ack_lvl = !ack_ok;
    phy_rdata = rdv;
    rises = 0; falls = 0; mdio_in = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    rejected = !wr && sgl && (phy != 5'd0);
    if (rejected) begin
      chk(done == 1'b1, "R11 immediate done", done, 1);
      chk(busy == 1'b0, "R11 busy stays low", busy, 0);
      chk(rd_data == 16'd0, "R11 rd_data", rd_data, 0);
      chk(ack_fail == 1'b1, "R11 ack_fail", ack_fail, 1);
      repeat (20 * HALF) @(negedge clk);
      chk(rises == 0, "R11 no MDC edges", rises, 0);
      return;
    end
    chk(busy == 1'b1 && done == 1'b0, "R10 busy after accept", {busy, done}, 2);
    if (poke) begin
      repeat (40) @(negedge clk);
      req_valid = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
    end
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, "R10 done seen", done, 1);
    chk(rises == 65, "R2 rising edge count", rises, 65);
    ef = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, wd};
    pre_bad = 0; hdr_bad = 0; tail_bad = 0; rel_bad = 0;
    for (int k = 0; k < 65; k++) begin
      if (k < 32) begin
        if (cap_out[k] !== 1'b1 || cap_oe[k] !== 1'b1) pre_bad++;
      end else if (k < 46) begin
        if (cap_out[k] !== ef[63-k] || cap_oe[k] !== 1'b1) hdr_bad++;
      end else if (wr) begin
        if (cap_oe[k] !== 1'b1) tail_bad++;
        else if (k < 64 && cap_out[k] !== ef[63-k]) tail_bad++;
        else if (k == 64 && cap_out[k] !== 1'b1) tail_bad++;
      end else begin
        if (cap_oe[k] !== 1'b0) rel_bad++;
      end
    end
    chk(pre_bad == 0, "R3 preamble bits", pre_bad, 0);
    chk(hdr_bad == 0, "R4 header bits", hdr_bad, 0);
    if (wr) chk(tail_bad == 0, "R5 turnaround/data/idle bits", tail_bad, 0);
    else    chk(rel_bad == 0, "R6 line released", rel_bad, 0);
    exp_rd = (!wr && ack_ok) ? rdv : 16'd0;
    exp_af = !wr && !ack_ok;
    chk(rd_data == exp_rd, wr ? "R5 write rd_data" : (ack_ok ? "R7 rd_data" : "R8 rd_data"),
        rd_data, exp_rd);
    chk(ack_fail == exp_af, wr ? "R5 write ack_fail" : (ack_ok ? "R7 ack_fail" : "R8 ack_fail"),
        ack_fail, exp_af);
    chk(mdio_oe == 1'b0 && busy == 1'b0, "R10 release with done", {mdio_oe, busy}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    if (poke) begin
      repeat (40 * HALF) @(negedge clk);
      chk(rises == 65 && !busy, "R10 request during busy ignored", rises, 65);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0 && busy == 0 && done == 0 && ack_fail == 0,
        "R1 reset outputs", {mdc, mdio_oe, busy, done, ack_fail}, 0);
    chk(rd_data == 16'd0, "R1 reset rd_data", rd_data, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(mdc == 1'b0 && rises == 0, "R2 MDC idle low", mdc, 0);

    for (int v = 0; v < NVEC; v++) begin
      run(VEC[v][44], VEC[v][43], VEC[v][42], VEC[v][41:37], VEC[v][36:32],
          VEC[v][31:16], VEC[v][15:0], 1'b0);
      if (v == 0)
        chk((rise_t[2] - rise_t[1]) == 2 * HALF * CLK_PERIOD, "R2 MDC period",
            int'(rise_t[2] - rise_t[1]), 2 * HALF * CLK_PERIOD);
    end

    // Corner: failed acknowledge while PHY shows alternating data (R8).
    run(1'b0, 1'b0, 1'b0, 5'd4, 5'd4, 16'h0000, 16'h5555, 1'b0);
    // Corner: request injected mid-frame must be ignored (R10).
    run(1'b0, 1'b0, 1'b1, 5'd2, 5'd3, 16'h0000, 16'hC3C3, 1'b1);
    run(1'b1, 1'b0, 1'b1, 5'd1, 5'd6, 16'h00FF, 16'h0000, 1'b1);
    // Corner: single-PHY reject with highest address (R11).
    run(1'b0, 1'b1, 1'b1, 5'd31, 5'd0, 16'h0000, 16'hFFFF, 1'b0);

    chk(r9_viol == 0, "R9 drive stable while MDC high", r9_viol, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule